// File: doc/BRIEF.md
# UART Transmit Queue with Guarded Empty Interrupt

This block is the transmit-side byte queue of a UART. It sits between a CPU write port and the transmit shift register. The CPU pushes bytes with a write strobe. When the shifter asks for its next character with a load request, the oldest byte is presented on the data output and removed from the queue. The queue holds up to sixteen bytes. Writes made while it is full are discarded, and a sticky status bit records each such loss.

The block raises an interrupt request when the queue is empty and transmit interrupts are enabled. A lone byte written by an interrupt handler can drain to the shifter before the handler writes the next one. Without a guard, the interrupt would then re-fire while that handler is still running. To stop this, a queue that has only ever held one byte since it was last empty keeps the interrupt low for one character time after it drains. The character time is a programmable number of bit-clock ticks. The guard is dropped once two bytes sit in the queue together, and from then on the next drain raises the interrupt at once.

Top module: `txq_irq_ctrl`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in write order. `full_o` is high exactly when 16 bytes are held, and `empty_o` is high exactly when none are held.
- R2: A write made while the queue is full is discarded. The queue contents and the oldest byte are unchanged, and `wr_ovf_o` goes high on the next edge and stays high until reset.
- R3: After one byte has been taken by the shifter from a full queue, the next write is accepted.
- R4: When `ld_req_i` is high and the queue is not empty, `ld_data_o` carries the oldest byte and that byte is removed at the clock edge. A load request on an empty queue has no effect.
- R5: `irq_o` is high when the queue is empty, `irq_en_i` is high and no hold-off is running.
- R6: A write accepted into an empty queue pulls `irq_o` low from the next clock edge.
- R7: When the queue drains from a single byte, and it has not held two bytes together since it was last empty, `irq_o` stays low until the edge that samples the `char_len_i`-th `char_tick_i` pulse after the drain.
- R8: Once the queue has held two or more bytes at the same time, its next drain raises `irq_o` on the following edge with no hold-off.
- R9: With `irq_en_i` low, `irq_o` is low, while queue and hold-off state keep tracking. Raising the enable on an empty queue with no hold-off running shows the interrupt at once.
- R10: After reset the queue is empty and not full, `wr_ovf_o` is low, and `irq_o` follows `irq_en_i`.
- R11: A `char_len_i` of zero disables the hold-off, so a single-byte drain raises `irq_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | DATA_W | CPU write byte |
| ld_req_i | input | 1 | Shifter request for the next byte |
| irq_en_i | input | 1 | Transmit interrupt enable |
| char_tick_i | input | 1 | Bit-clock tick used to time the hold-off |
| char_len_i | input | CNT_W | Hold-off length in ticks (one character time) |
| ld_data_o | output | DATA_W | Oldest queued byte, handed to the shifter |
| full_o | output | 1 | Queue holds DEPTH bytes |
| empty_o | output | 1 | Queue holds no byte |
| irq_o | output | 1 | Queue-empty interrupt request |
| wr_ovf_o | output | 1 | Sticky flag: a write was discarded |

## Verification
Every result is taken from registered state, so a write, a load or an overflow shows on `full_o`, `empty_o`, `wr_ovf_o` and `irq_o` one edge after the strobe. The one exception is that `irq_o` follows `irq_en_i` within the same cycle. `ld_data_o` is valid in the cycle of the load request, before the edge that removes the byte. The hold-off releases on the edge that samples the last counted tick. The bench drives inputs on the falling edge, checks `ld_data_o` right there, and checks every other output one nanosecond after the following rising edge against a queue model updated for exactly that edge.

// File: rtl/txq_pkg.sv
package txq_pkg;

    // Hold-off mode of the empty-interrupt guard
    typedef enum logic {
        HO_FAST  = 1'b0,   // queue has held two bytes together: no delay on drain
        HO_GUARD = 1'b1    // only a lone byte since last empty: delay on drain
    } ho_mode_e;

    localparam int unsigned TXQ_DEF_DATA_W = 8;
    localparam int unsigned TXQ_DEF_DEPTH  = 16;
    localparam int unsigned TXQ_DEF_CNT_W  = 8;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int unsigned DATA_W = txq_pkg::TXQ_DEF_DATA_W,
    parameter int unsigned DEPTH  = txq_pkg::TXQ_DEF_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              full_o,
    output logic              empty_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = ptr_inc(st_q.wp);
        if (pop_i)  st_d.rp = ptr_inc(st_q.rp);
        unique case ({push_i, pop_i})
            2'b10:   st_d.lvl = st_q.lvl + LVL_W'(1);
            2'b01:   st_d.lvl = st_q.lvl - LVL_W'(1);
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[st_q.wp] <= wdata_i;
    end

    assign rdata_o = mem_q[st_q.rp];
    assign level_o = st_q.lvl;
    assign full_o  = (st_q.lvl == LVL_W'(DEPTH));
    assign empty_o = (st_q.lvl == '0);

    // R1: occupancy never exceeds the depth
    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(DEPTH));
    // R2: the controller never pushes into a full queue
    a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R4: the controller never pops an empty queue
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/txq_holdoff.sv
module txq_holdoff #(
    parameter int unsigned CNT_W = txq_pkg::TXQ_DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_i,   // write accepted into empty queue
    input  logic             pair_i,    // two or more bytes held after this edge
    input  logic             drain_i,   // last byte leaves, no write alongside
    input  logic             push_i,    // any accepted write
    input  logic             tick_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             hold_o,
    output logic             guard_o
);
    import txq_pkg::*;

    typedef struct packed {
        ho_mode_e         mode;
        logic [CNT_W-1:0] left;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (first_i)     st_d.mode = HO_GUARD;
        else if (pair_i) st_d.mode = HO_FAST;

        if (push_i)
            st_d.left = '0;
        else if (drain_i)
            st_d.left = (st_q.mode == HO_GUARD) ? len_i : '0;
        else if (tick_i && st_q.left != '0)
            st_d.left = st_q.left - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: HO_FAST, left: '0};
        else        st_q <= st_d;
    end

    assign hold_o  = (st_q.left != '0);
    assign guard_o = (st_q.mode == HO_GUARD);

    // R7: a guarded drain with non-zero length starts the hold-off
    a_r7_hold_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && guard_o && len_i != '0) |=> hold_o);
    // R7: without a tick or a write the hold-off keeps running
    a_r7_hold_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !tick_i && !push_i) |=> hold_o);
    // R8: holding two bytes together removes the guard
    a_r8_pair_clears_guard: assert property (@(posedge clk) disable iff (!rst_n)
        pair_i |=> !guard_o);
    // R8: an unguarded drain starts no hold-off
    a_r8_fast_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && !guard_o) |=> !hold_o);

endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl #(
    parameter int unsigned DATA_W = txq_pkg::TXQ_DEF_DATA_W,
    parameter int unsigned DEPTH  = txq_pkg::TXQ_DEF_DEPTH,
    parameter int unsigned CNT_W  = txq_pkg::TXQ_DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ld_req_i,
    input  logic              irq_en_i,
    input  logic              char_tick_i,
    input  logic [CNT_W-1:0]  char_len_i,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              irq_o,
    output logic              wr_ovf_o
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovf;
    } st_t;

    st_t st_d, st_q;

    logic             push, pop, first_ld, drain, pair, hold, guard;
    logic [LVL_W-1:0] level, level_nxt;

    assign push = wr_en_i && !full_o;
    assign pop  = ld_req_i && !empty_o;

    always_comb begin
        level_nxt = level;
        if (push && !pop) level_nxt = level + LVL_W'(1);
        if (pop && !push) level_nxt = level - LVL_W'(1);
    end

    assign first_ld = push && empty_o;
    assign drain    = pop && !push && (level == LVL_W'(1));
    assign pair     = (level_nxt >= LVL_W'(2));

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (wr_data_i),
        .rdata_o (ld_data_o),
        .level_o (level),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    txq_holdoff #(.CNT_W(CNT_W)) holdoff_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_i (first_ld),
        .pair_i  (pair),
        .drain_i (drain),
        .push_i  (push),
        .tick_i  (char_tick_i),
        .len_i   (char_len_i),
        .hold_o  (hold),
        .guard_o (guard)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i && full_o) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ovf_o = st_q.ovf;
    assign irq_o    = irq_en_i && empty_o && !hold;

    // R2: a refused write sets the sticky flag
    a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && full_o) |=> wr_ovf_o);
    // R2: the flag stays set
    a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovf_o |=> wr_ovf_o);
    // R6: loading an empty queue drops the request
    a_r6_first_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && empty_o) |=> !irq_o);
    // R8: an unguarded drain raises the request at once
    a_r8_drain_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !guard) |=> (irq_o || !irq_en_i || !empty_o));

endmodule

// File: tb/txq_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module txq_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, ld_req = 1'b0, irq_en = 1'b1, tick = 1'b0;
    logic [7:0] wr_data = '0, ld_data;
    logic [7:0] len = 8'd3;
    logic       full, empty, irq, ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [7:0] mq[$];
    bit         m_guard = 1'b0;
    int         m_hold  = 0;
    bit         m_ovf   = 1'b0;

    always #2.5 clk = ~clk;

    txq_irq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .ld_req_i    (ld_req),
        .irq_en_i    (irq_en),
        .char_tick_i (tick),
        .char_len_i  (len),
        .ld_data_o   (ld_data),
        .full_o      (full),
        .empty_o     (empty),
        .irq_o       (irq),
        .wr_ovf_o    (ovf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_irq();
        return irq_en && (mq.size() == 0) && (m_hold == 0);
    endfunction

    task automatic check_all();
        check(full  == (mq.size() == 16), "R1 full",  full,  mq.size() == 16);
        check(empty == (mq.size() == 0),  "R1 empty", empty, mq.size() == 0);
        check(irq   == exp_irq(),         "R5 irq",   irq,   exp_irq());
        check(ovf   == m_ovf,             "R2 ovf",   ovf,   m_ovf);
    endtask

    // one clock: drive at falling edge, update model, sample 1 ns after rising edge
    task automatic step(input bit wr, input logic [7:0] dat, input bit ld,
                        input bit en, input bit tk);
        bit acc, pop, drn;
        int sz;
        @(negedge clk);
        wr_en = wr; wr_data = dat; ld_req = ld; irq_en = en; tick = tk;
        #0.5;
        sz  = mq.size();
        acc = wr && (sz < 16);
        pop = ld && (sz > 0);
        drn = pop && !acc && (sz == 1);
        if (pop) check(ld_data == mq[0], "R4 load data", ld_data, mq[0]);
        if (wr && sz == 16) m_ovf = 1'b1;
        if (pop) void'(mq.pop_front());
        if (acc) mq.push_back(dat);
        if (acc)      m_hold = 0;
        else if (drn) m_hold = m_guard ? int'(len) : 0;
        else if (tk && m_hold > 0) m_hold--;
        if (acc && sz == 0)    m_guard = 1'b1;
        else if (mq.size() >= 2) m_guard = 1'b0;
        @(posedge clk);
        #1;
        check_all();
        wr_en = 1'b0; ld_req = 1'b0; tick = 1'b0;
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(empty == 1'b1, "R10 empty", empty, 1);
        check(full  == 1'b0, "R10 full",  full,  0);
        check(ovf   == 1'b0, "R10 ovf",   ovf,   0);
        check(irq   == 1'b1, "R10 irq",   irq,   1);
        @(negedge clk) rst_n = 1'b1;

        // R4: load request on empty queue has no effect
        step(0, 8'h00, 1, 1, 0);
        check(empty == 1'b1, "R4 empty load", empty, 1);

        // R6: first byte drops the request
        len = 8'd3;
        step(1, 8'hA5, 0, 1, 0);
        check(irq == 1'b0, "R6 first write", irq, 0);

        // R7: lone byte drains, hold for three ticks
        step(0, 8'h00, 1, 1, 0);
        check(irq == 1'b0, "R7 hold after drain", irq, 0);
        step(0, 8'h00, 0, 1, 1);
        step(0, 8'h00, 0, 1, 0);
        step(0, 8'h00, 0, 1, 1);
        check(irq == 1'b0, "R7 hold before last tick", irq, 0);
        step(0, 8'h00, 0, 1, 1);
        check(irq == 1'b1, "R7 release on last tick", irq, 1);

        // R8: two bytes held together -> immediate request on drain
        step(1, 8'h11, 0, 1, 0);
        step(1, 8'h22, 0, 1, 0);
        step(0, 8'h00, 1, 1, 0);
        step(0, 8'h00, 1, 1, 0);
        check(irq == 1'b1, "R8 no hold-off", irq, 1);

        // R11: zero length disables the hold-off
        len = 8'd0;
        step(1, 8'h33, 0, 1, 0);
        step(0, 8'h00, 1, 1, 0);
        check(irq == 1'b1, "R11 zero length", irq, 1);

        // R9: enable low gates the request; state keeps tracking
        len = 8'd2;
        step(0, 8'h00, 0, 0, 0);
        check(irq == 1'b0, "R9 gated", irq, 0);
        step(1, 8'h44, 0, 0, 0);
        step(0, 8'h00, 1, 0, 0);
        step(0, 8'h00, 0, 1, 0);
        check(irq == 1'b0, "R9 hold kept while gated", irq, 0);
        step(0, 8'h00, 0, 1, 1);
        step(0, 8'h00, 0, 1, 1);
        check(irq == 1'b1, "R9 shown after hold", irq, 1);

        // R1, R2, R3: fill, overflow, refill
        for (int i = 0; i < 16; i++) step(1, 8'(8'h80 + i), 0, 1, 0);
        check(full == 1'b1, "R1 full at 16", full, 1);
        step(1, 8'hEE, 0, 1, 0);
        check(ovf == 1'b1, "R2 overflow flag", ovf, 1);
        check(ld_data == 8'h80, "R2 oldest unchanged", ld_data, 8'h80);
        step(0, 8'h00, 1, 1, 0);
        step(1, 8'h5A, 0, 1, 0);
        check(full == 1'b1, "R3 write accepted after load", full, 1);
        for (int i = 0; i < 16; i++) step(0, 8'h00, 1, 1, 0);
        check(empty == 1'b1, "R1 drained in order", empty, 1);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 64) == 0) len = 8'($urandom % 6);
            step(($urandom % 100) < 45, 8'($urandom), ($urandom % 100) < 40,
                 ($urandom % 100) < 90, ($urandom % 100) < 35);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule